// File: doc/BRIEF.md
# Issue Scheduling Queue for One Execution Unit

This block sits between the scoreboard stage and one execution unit. Instructions that the scoreboard releases ask to enter the queue; they get in only when the register-file read schedulers grant operand reads. Each entry then waits until its operand reads report complete. Every cycle the queue searches from its oldest slot towards its newest. The first entry with complete operands moves into a single-entry issue slot, provided the unit can accept work and the slot is empty. The execute stage empties that slot with a take strobe.

A second entry path lets an instruction come back with its operands already read. Such an instruction is placed by wavefront age rather than at the tail. When a memory-reference instruction leaves the queue, the execution mask of its wavefront is sampled from a mask bus and travels with it. Five free-running counters split the lost cycles into causes: refused read-port access, a full queue, ready entries passed over, a blocked unit, and operands still in flight.

Top module: `issue_queue`

## Requirements
- R1: An enqueue request with `enq_scalar`=0 is accepted only when both `vrf_grant` and `srf_grant` are 1; with `enq_scalar`=1 only `srf_grant` is needed and `vrf_grant` is ignored.
- R2: An enqueue request without the grants it needs is dropped and `stall_rf` increases by one for that cycle.
- R3: Holding `DEPTH` entries, the queue refuses both enqueue and reinsert. An enqueue arriving in the same cycle as a reinsert is refused. Each refused request adds one to `stall_add`.
- R4: An entry starts with its operands busy. A completion report (`rd_cpl_valid` with matching `rd_cpl_tag`) records vector and scalar read completion separately. A non-scalar entry becomes ready once both are recorded; a scalar entry needs only the scalar one.
- R5: In a cycle where `unit_ready`=1 and the slot is empty, the ready entry nearest the head is removed. It appears on the slot outputs after that clock edge. At most one entry leaves per cycle, and entries keep their relative order.
- R6: A filled slot keeps its contents until `slot_take` is 1 at a clock edge, and nothing is moved into it meanwhile.
- R7: Each cycle `stall_sched` grows by the number of ready entries that were not moved to the slot.
- R8: Each cycle with at least one ready entry that cannot be issued (unit not ready or slot occupied), `stall_res` grows by one.
- R9: Each cycle `stall_opd` grows by the number of entries whose operands are still busy.
- R10: A reinserted instruction enters ready. It is placed directly in front of the first entry whose wavefront id is greater than or equal to its own, or at the tail if there is none.
- R11: For a memory-reference instruction, `slot_mask` holds bits `[w*MASK_W +: MASK_W]` of `exec_masks`, sampled in the issue cycle (w being its wavefront id); otherwise `slot_mask` is zero.
- R12: Synchronous reset empties the queue and the slot and zeroes all five counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | New instruction from the scoreboard |
| enq_tag | input | TAG_W | Instruction tag |
| enq_wfid | input | WID_W | Wavefront id |
| enq_scalar | input | 1 | Instruction reads scalar operands only |
| enq_mem | input | 1 | Instruction references memory |
| vrf_grant | input | 1 | Vector register-file read grant |
| srf_grant | input | 1 | Scalar register-file read grant |
| rd_cpl_valid | input | 1 | Operand read completion report |
| rd_cpl_tag | input | TAG_W | Tag the report applies to |
| rd_cpl_vec | input | 1 | Vector reads finished |
| rd_cpl_sca | input | 1 | Scalar reads finished |
| rein_valid | input | 1 | Reinsert an instruction with operands ready |
| rein_tag | input | TAG_W | Reinsert tag |
| rein_wfid | input | WID_W | Reinsert wavefront id |
| rein_scalar | input | 1 | Reinsert scalar flag |
| rein_mem | input | 1 | Reinsert memory flag |
| unit_ready | input | 1 | Execution unit can accept an instruction |
| exec_masks | input | (2**WID_W)*MASK_W | Current execution mask of every wavefront |
| slot_take | input | 1 | Execute stage consumes the slot |
| slot_valid | output | 1 | Slot holds an instruction |
| slot_tag | output | TAG_W | Slot instruction tag |
| slot_wfid | output | WID_W | Slot wavefront id |
| slot_mem | output | 1 | Slot instruction references memory |
| slot_mask | output | MASK_W | Captured execution mask |
| stall_rf | output | CNT_W | Refused read-port access count |
| stall_add | output | CNT_W | Full or collided entry count |
| stall_sched | output | CNT_W | Ready entries passed over |
| stall_res | output | CNT_W | Cycles blocked by the unit or slot |
| stall_opd | output | CNT_W | Busy-operand entry-cycles |

## Verification
Some properties are checked on every cycle. A filled slot is never overwritten before a take. A slot only fills after a cycle in which the unit was ready. Entry occupancy never exceeds the depth. A refused grant always bumps the access-stall count. A non-memory issue always carries a zero mask. Issue order is shown only by the bench's scenarios: the first-ready scan passing over busy entries, age-ordered reinsertion among existing entries, and refusal of the entry past a full queue. The same holds for the exact per-cycle growth of the operand, resource and skip counters.

// File: rtl/iq_pkg.sv
package iq_pkg;
  typedef enum logic {
    SLOT_EMPTY = 1'b0,
    SLOT_LOADED = 1'b1
  } slot_state_e;
endpackage

// File: rtl/iq_scan.sv
// Finds the oldest ready entry and counts ready and busy entries.
module iq_scan #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0] rdy,
  input  logic [DEPTH-1:0] busy,
  output logic             any_rdy,
  output logic [IW-1:0]    first_idx,
  output logic [CW-1:0]    n_rdy,
  output logic [CW-1:0]    n_busy
);
  always_comb begin
    any_rdy   = 1'b0;
    first_idx = '0;
    n_rdy     = '0;
    n_busy    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rdy[i] && !any_rdy) begin
        any_rdy   = 1'b1;
        first_idx = IW'(i);
      end
      n_rdy  = n_rdy + CW'(rdy[i]);
      n_busy = n_busy + CW'(busy[i]);
    end
  end
endmodule

// File: rtl/iq_place.sv
// Position in front of the first entry whose wavefront id is not smaller than the key.
module iq_place #(
  parameter int DEPTH = 8,
  parameter int WID_W = 3,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH*WID_W-1:0] wf_flat,
  input  logic [CW-1:0]          cnt,
  input  logic [WID_W-1:0]       key,
  output logic [CW-1:0]          pos
);
  always_comb begin
    pos = cnt;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if ((i < int'(cnt)) && (wf_flat[i*WID_W +: WID_W] >= key)) pos = CW'(i);
    end
  end
endmodule

// File: rtl/issue_queue.sv
module issue_queue #(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 8,
  parameter int WID_W  = 3,
  parameter int MASK_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            enq_valid,
  input  logic [TAG_W-1:0]                enq_tag,
  input  logic [WID_W-1:0]                enq_wfid,
  input  logic                            enq_scalar,
  input  logic                            enq_mem,
  input  logic                            vrf_grant,
  input  logic                            srf_grant,
  input  logic                            rd_cpl_valid,
  input  logic [TAG_W-1:0]                rd_cpl_tag,
  input  logic                            rd_cpl_vec,
  input  logic                            rd_cpl_sca,
  input  logic                            rein_valid,
  input  logic [TAG_W-1:0]                rein_tag,
  input  logic [WID_W-1:0]                rein_wfid,
  input  logic                            rein_scalar,
  input  logic                            rein_mem,
  input  logic                            unit_ready,
  input  logic [(2**WID_W)*MASK_W-1:0]    exec_masks,
  input  logic                            slot_take,
  output logic                            slot_valid,
  output logic [TAG_W-1:0]                slot_tag,
  output logic [WID_W-1:0]                slot_wfid,
  output logic                            slot_mem,
  output logic [MASK_W-1:0]               slot_mask,
  output logic [CNT_W-1:0]                stall_rf,
  output logic [CNT_W-1:0]                stall_add,
  output logic [CNT_W-1:0]                stall_sched,
  output logic [CNT_W-1:0]                stall_res,
  output logic [CNT_W-1:0]                stall_opd
);
  import iq_pkg::*;

  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  // Queue storage, index 0 is the head.
  logic [TAG_W-1:0] q_tag [DEPTH];
  logic [WID_W-1:0] q_wf  [DEPTH];
  logic             q_sc  [DEPTH];
  logic             q_mem [DEPTH];
  logic             q_vd  [DEPTH];
  logic             q_sd  [DEPTH];
  logic [CW-1:0]    q_cnt;

  slot_state_e slot_st;
  assign slot_valid = (slot_st == SLOT_LOADED);

  // Readiness of each stored entry.
  logic [DEPTH-1:0] rdy, busy;
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      rdy[i]  = (i < int'(q_cnt)) && q_sd[i] && (q_sc[i] || q_vd[i]);
      busy[i] = (i < int'(q_cnt)) && !rdy[i];
    end
  end

  logic          any_rdy;
  logic [IW-1:0] first_idx;
  logic [CW-1:0] n_rdy, n_busy;

  iq_scan #(.DEPTH(DEPTH)) u_scan (
    .rdy(rdy), .busy(busy), .any_rdy(any_rdy),
    .first_idx(first_idx), .n_rdy(n_rdy), .n_busy(n_busy)
  );

  logic can_issue, disp, full, grant_ok, enq_acc, rein_acc, do_ins;
  assign can_issue = unit_ready && !slot_valid;
  assign disp      = any_rdy && can_issue;
  assign full      = (q_cnt == CW'(DEPTH));
  assign grant_ok  = srf_grant && (enq_scalar || vrf_grant);
  assign rein_acc  = rein_valid && !full;
  assign enq_acc   = enq_valid && grant_ok && !full && !rein_valid;
  assign do_ins    = rein_acc || enq_acc;

  // Completion updates, then removal of the issued entry (no holes).
  logic [TAG_W-1:0] c_tag [DEPTH];
  logic [WID_W-1:0] c_wf  [DEPTH];
  logic             c_sc  [DEPTH];
  logic             c_mem [DEPTH];
  logic             c_vd  [DEPTH];
  logic             c_sd  [DEPTH];
  logic [DEPTH*WID_W-1:0] c_wf_flat;
  logic [CW-1:0]    c_cnt;
  int src;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      src = (disp && (i >= int'(first_idx))) ? i + 1 : i;
      if (src > DEPTH - 1) src = DEPTH - 1;
      c_tag[i] = q_tag[src];
      c_wf[i]  = q_wf[src];
      c_sc[i]  = q_sc[src];
      c_mem[i] = q_mem[src];
      c_vd[i]  = q_vd[src] | (rd_cpl_valid && rd_cpl_vec && (rd_cpl_tag == q_tag[src]));
      c_sd[i]  = q_sd[src] | (rd_cpl_valid && rd_cpl_sca && (rd_cpl_tag == q_tag[src]));
      c_wf_flat[i*WID_W +: WID_W] = c_wf[i];
    end
    c_cnt = q_cnt - CW'(disp);
  end

  logic [CW-1:0] age_pos, ins_pos;
  iq_place #(.DEPTH(DEPTH), .WID_W(WID_W)) u_place (
    .wf_flat(c_wf_flat), .cnt(c_cnt), .key(rein_wfid), .pos(age_pos)
  );
  assign ins_pos = rein_valid ? age_pos : c_cnt;

  // Insertion of the reinserted or new instruction.
  logic [TAG_W-1:0] i_tag;
  logic [WID_W-1:0] i_wf;
  logic             i_sc, i_mem, i_rdy;
  assign i_tag = rein_valid ? rein_tag    : enq_tag;
  assign i_wf  = rein_valid ? rein_wfid   : enq_wfid;
  assign i_sc  = rein_valid ? rein_scalar : enq_scalar;
  assign i_mem = rein_valid ? rein_mem    : enq_mem;
  assign i_rdy = rein_valid;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (do_ins && (i == int'(ins_pos))) begin
        q_tag[i] <= i_tag; q_wf[i] <= i_wf; q_sc[i] <= i_sc;
        q_mem[i] <= i_mem; q_vd[i] <= i_rdy; q_sd[i] <= i_rdy;
      end else if (do_ins && (i > int'(ins_pos)) && (i > 0)) begin
        q_tag[i] <= c_tag[i-1]; q_wf[i] <= c_wf[i-1]; q_sc[i] <= c_sc[i-1];
        q_mem[i] <= c_mem[i-1]; q_vd[i] <= c_vd[i-1]; q_sd[i] <= c_sd[i-1];
      end else begin
        q_tag[i] <= c_tag[i]; q_wf[i] <= c_wf[i]; q_sc[i] <= c_sc[i];
        q_mem[i] <= c_mem[i]; q_vd[i] <= c_vd[i]; q_sd[i] <= c_sd[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q_cnt <= '0;
    else     q_cnt <= c_cnt + CW'(do_ins);
  end

  // Issue slot.
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_st   <= SLOT_EMPTY;
      slot_tag  <= '0;
      slot_wfid <= '0;
      slot_mem  <= 1'b0;
      slot_mask <= '0;
    end else if (slot_valid && slot_take) begin
      slot_st <= SLOT_EMPTY;
    end else if (disp) begin
      slot_st   <= SLOT_LOADED;
      slot_tag  <= q_tag[first_idx];
      slot_wfid <= q_wf[first_idx];
      slot_mem  <= q_mem[first_idx];
      slot_mask <= q_mem[first_idx] ? exec_masks[q_wf[first_idx]*MASK_W +: MASK_W] : '0;
    end
  end

  // Stall accounting.
  logic [1:0] add_inc;
  assign add_inc = 2'(enq_valid && grant_ok && (full || rein_valid)) + 2'(rein_valid && full);

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_rf <= '0; stall_add <= '0; stall_sched <= '0;
      stall_res <= '0; stall_opd <= '0;
    end else begin
      stall_rf    <= stall_rf + CNT_W'(enq_valid && !grant_ok);
      stall_add   <= stall_add + CNT_W'(add_inc);
      stall_sched <= stall_sched + CNT_W'(n_rdy - CW'(disp));
      stall_res   <= stall_res + CNT_W'(any_rdy && !can_issue);
      stall_opd   <= stall_opd + CNT_W'(n_busy);
    end
  end
endmodule

// File: rtl/iq_checker.sv
module iq_checker #(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 8,
  parameter int MASK_W = 8,
  parameter int CNT_W  = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              enq_valid,
  input logic              enq_scalar,
  input logic              vrf_grant,
  input logic              srf_grant,
  input logic              unit_ready,
  input logic              slot_take,
  input logic              slot_valid,
  input logic [TAG_W-1:0]  slot_tag,
  input logic              slot_mem,
  input logic [MASK_W-1:0] slot_mask,
  input logic [CNT_W-1:0]  stall_rf,
  input logic [CW-1:0]     q_cnt
);
  p_slot_hold_r6: assert property (@(posedge clk) disable iff (rst)
    slot_valid && !slot_take |=> slot_valid && $stable(slot_tag));

  p_fill_needs_unit_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(slot_valid) |-> $past(unit_ready));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    q_cnt <= CW'(DEPTH));

  p_deny_counted_r2: assert property (@(posedge clk) disable iff (rst)
    enq_valid && !(srf_grant && (enq_scalar || vrf_grant))
      |=> stall_rf == CNT_W'($past(stall_rf) + 1'b1));

  p_mask_zero_r11: assert property (@(posedge clk) disable iff (rst)
    slot_valid && !slot_mem |-> slot_mask == '0);
endmodule

bind issue_queue iq_checker #(
  .DEPTH(DEPTH), .TAG_W(TAG_W), .MASK_W(MASK_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_scalar(enq_scalar),
  .vrf_grant(vrf_grant), .srf_grant(srf_grant), .unit_ready(unit_ready),
  .slot_take(slot_take), .slot_valid(slot_valid), .slot_tag(slot_tag),
  .slot_mem(slot_mem), .slot_mask(slot_mask), .stall_rf(stall_rf), .q_cnt(q_cnt)
);

// File: tb/issue_queue_tb.sv
module issue_queue_tb;
  localparam int DEPTH = 8, TAG_W = 8, WID_W = 3, MASK_W = 8, CNT_W = 16;
  localparam int NWF = 2**WID_W;

  logic clk = 1'b0, rst = 1'b1;
  logic enq_valid = 0, enq_scalar = 0, enq_mem = 0, vrf_grant = 0, srf_grant = 0;
  logic [TAG_W-1:0] enq_tag = '0, rd_cpl_tag = '0, rein_tag = '0;
  logic [WID_W-1:0] enq_wfid = '0, rein_wfid = '0;
  logic rd_cpl_valid = 0, rd_cpl_vec = 0, rd_cpl_sca = 0;
  logic rein_valid = 0, rein_scalar = 0, rein_mem = 0, unit_ready = 0, slot_take = 0;
  logic [NWF*MASK_W-1:0] exec_masks;
  logic slot_valid, slot_mem;
  logic [TAG_W-1:0] slot_tag;
  logic [WID_W-1:0] slot_wfid;
  logic [MASK_W-1:0] slot_mask;
  logic [CNT_W-1:0] stall_rf, stall_add, stall_sched, stall_res, stall_opd;

  always #2 clk = ~clk;

  issue_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .WID_W(WID_W), .MASK_W(MASK_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_tag(enq_tag), .enq_wfid(enq_wfid),
    .enq_scalar(enq_scalar), .enq_mem(enq_mem), .vrf_grant(vrf_grant), .srf_grant(srf_grant),
    .rd_cpl_valid(rd_cpl_valid), .rd_cpl_tag(rd_cpl_tag), .rd_cpl_vec(rd_cpl_vec),
    .rd_cpl_sca(rd_cpl_sca), .rein_valid(rein_valid), .rein_tag(rein_tag),
    .rein_wfid(rein_wfid), .rein_scalar(rein_scalar), .rein_mem(rein_mem),
    .unit_ready(unit_ready), .exec_masks(exec_masks), .slot_take(slot_take),
    .slot_valid(slot_valid), .slot_tag(slot_tag), .slot_wfid(slot_wfid),
    .slot_mem(slot_mem), .slot_mask(slot_mask), .stall_rf(stall_rf),
    .stall_add(stall_add), .stall_sched(stall_sched), .stall_res(stall_res),
    .stall_opd(stall_opd)
  );

  int n_chk = 0, n_bad = 0;
  logic [TAG_W+WID_W+1+MASK_W-1:0] exp_q[$];

  function automatic logic [MASK_W-1:0] mask_of(int w);
    return MASK_W'(8'h1F * (w + 1)) ^ MASK_W'(8'h5A);
  endfunction

  initial begin
    for (int w = 0; w < NWF; w++) exec_masks[w*MASK_W +: MASK_W] = mask_of(w);
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_exp(int tag, int wf, bit mem);
    exp_q.push_back({TAG_W'(tag), WID_W'(wf), mem, mem ? mask_of(wf) : MASK_W'(0)});
  endtask

  // Monitor: compares each issued instruction, checks it holds, then takes it.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && slot_valid && !slot_take) begin
        if (exp_q.size() == 0) begin
          check(0, "R5 unexpected issue", int'(slot_tag), -1);
        end else begin
          logic [TAG_W+WID_W+1+MASK_W-1:0] e;
          e = exp_q.pop_front();
          check({slot_tag, slot_wfid, slot_mem, slot_mask} == e, "R5/R11 issue item",
                int'({slot_tag, slot_wfid, slot_mem, slot_mask}), int'(e));
        end
        begin
          logic [TAG_W-1:0] held;
          held = slot_tag;
          @(negedge clk);
          check(slot_valid && slot_tag == held, "R6 slot hold", int'(slot_tag), int'(held));
        end
        slot_take = 1;
        @(negedge clk);
        slot_take = 0;
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_enq(int tag, int wf, bit sc, bit mem, bit vg, bit sg);
    enq_valid = 1; enq_tag = TAG_W'(tag); enq_wfid = WID_W'(wf); enq_scalar = sc;
    enq_mem = mem; vrf_grant = vg; srf_grant = sg;
    @(negedge clk);
    enq_valid = 0; vrf_grant = 0; srf_grant = 0;
  endtask

  task automatic do_cpl(int tag, bit v, bit s);
    rd_cpl_valid = 1; rd_cpl_tag = TAG_W'(tag); rd_cpl_vec = v; rd_cpl_sca = s;
    @(negedge clk);
    rd_cpl_valid = 0; rd_cpl_vec = 0; rd_cpl_sca = 0;
  endtask

  task automatic do_rein(int tag, int wf, bit sc, bit mem);
    rein_valid = 1; rein_tag = TAG_W'(tag); rein_wfid = WID_W'(wf);
    rein_scalar = sc; rein_mem = mem;
    @(negedge clk);
    rein_valid = 0;
  endtask

  task automatic drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    idle(4);
    check(exp_q.size() == 0, "R5 drain", exp_q.size(), 0);
  endtask

  task automatic do_reset();
    unit_ready = 0;
    rst = 1;
    idle(2);
    rst = 0;
    idle(1);
  endtask

  // Watchdog.
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int a, b, c;
    do_reset();
    // R12: reset state
    check(!slot_valid, "R12 slot empty", slot_valid, 0);
    check((stall_rf | stall_add | stall_sched | stall_res | stall_opd) == 0,
          "R12 counters", int'(stall_rf | stall_add | stall_sched | stall_res | stall_opd), 0);

    // R1/R2/R4: grants and operand completion
    do_enq(1, 2, 0, 1, 1, 1);     // vector, both grants
    do_enq(2, 1, 0, 0, 0, 1);     // vector, no vector grant -> dropped
    do_enq(3, 0, 1, 0, 0, 1);     // scalar, vector grant ignored
    idle(1);
    check(stall_rf == 1, "R2 rf stall", int'(stall_rf), 1);
    do_cpl(3, 0, 1);              // scalar ready with scalar read only
    do_cpl(1, 1, 0);              // vector still waits for scalar part
    push_exp(3, 0, 0);
    unit_ready = 1;
    drain();
    a = int'(stall_opd);
    idle(3);
    check(!slot_valid, "R4 vector entry still busy", slot_valid, 0);
    check(int'(stall_opd) - a == 3, "R9 one busy entry", int'(stall_opd) - a, 3);
    push_exp(1, 2, 1);
    do_cpl(1, 0, 1);
    drain();

    // R7/R8/R9: counter growth while the unit is blocked
    do_reset();
    do_enq(10, 1, 0, 0, 1, 1);
    do_enq(11, 4, 0, 0, 1, 1);
    a = int'(stall_opd);
    idle(5);
    check(int'(stall_opd) - a == 10, "R9 two busy entries", int'(stall_opd) - a, 10);
    do_cpl(10, 1, 1);
    do_cpl(11, 1, 1);
    a = int'(stall_res); b = int'(stall_sched); c = int'(stall_opd);
    idle(5);
    check(int'(stall_res) - a == 5, "R8 resource stall", int'(stall_res) - a, 5);
    check(int'(stall_sched) - b == 10, "R7 passed-over ready", int'(stall_sched) - b, 10);
    check(int'(stall_opd) - c == 0, "R9 no busy entries", int'(stall_opd) - c, 0);
    push_exp(10, 1, 0);
    push_exp(11, 4, 0);
    unit_ready = 1;
    drain();

    // R3/R5: fill to depth, refuse one more, issue in order
    do_reset();
    for (int i = 0; i < DEPTH; i++) do_enq(20 + i, i, 1, i % 2, 1, 1);
    a = int'(stall_add);
    do_enq(28, 0, 1, 0, 1, 1);
    check(int'(stall_add) - a == 1, "R3 full refusal", int'(stall_add) - a, 1);
    for (int i = DEPTH - 1; i >= 0; i--) do_cpl(20 + i, 0, 1);
    for (int i = 0; i < DEPTH; i++) push_exp(20 + i, i, i % 2);
    unit_ready = 1;
    drain();

    // R10/R3: age-ordered reinsertion, collision with enqueue
    do_reset();
    do_enq(30, 1, 1, 0, 1, 1);
    do_enq(31, 3, 1, 0, 1, 1);
    do_enq(32, 5, 1, 1, 1, 1);
    do_rein(40, 3, 1, 1);         // lands before 31
    a = int'(stall_add);
    enq_valid = 1; enq_tag = 50; enq_wfid = 2; enq_scalar = 1; enq_mem = 0;
    vrf_grant = 1; srf_grant = 1;
    do_rein(41, 6, 0, 0);         // tail; enqueue of 50 refused
    enq_valid = 0; vrf_grant = 0; srf_grant = 0;
    check(int'(stall_add) - a == 1, "R3 reinsert collision", int'(stall_add) - a, 1);
    do_rein(42, 0, 1, 1);         // head
    do_cpl(30, 0, 1);
    do_cpl(31, 0, 1);
    do_cpl(32, 0, 1);
    push_exp(42, 0, 1);
    push_exp(30, 1, 0);
    push_exp(40, 3, 1);
    push_exp(31, 3, 0);
    push_exp(32, 5, 1);
    push_exp(41, 6, 0);
    unit_ready = 1;
    drain();
    idle(6);
    check(!slot_valid, "R10 R3 nothing extra issued", slot_valid, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule